// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 32-bit processor's register file and a 32-bit data bus whose bytes travel on four lanes. A request carries an access size (byte, word or longword), an address and, for a store, a full register value. The unit registers the request and presents it on the bus one cycle later. On that cycle it drives the byte-lane enables and puts the store data onto the lanes the address selects. When the read data of a load returns, the unit picks the addressed bytes out of the bus word and sign-extends them to a 32-bit register value in the same cycle.

Word and longword requests that break the natural alignment are not split into smaller accesses. They raise an address-error pulse, and no bus access takes place. The byte order is taken from a strap input while power-on reset is held. It is then locked until the next reset, so the strap pin needs no synchronising and no care after start-up.

Top module: `lsa_unit`

## Requirements
- R1: `req_size` encodes 0 = byte, 1 = word, 2 = longword. A legal request produces exactly one, two adjacent or all four set bits on `bus_be`, matching its size; `bus_be` is zero whenever `bus_valid` is low.
- R2: In big-endian mode the byte at address 4n+i sits on lane 3-i, where lane k is bits 8k+7:8k of the bus word. A word covers the two lanes of its two bytes, and the byte at its lower address is the more significant half.
- R3: In little-endian mode the byte at address 4n+i sits on lane i, and the byte at the higher address of a word or longword is the more significant one.
- R4: A store places the register's low byte (byte access) or low halfword (word access) on every enabled lane with the byte order of R2/R3, and the full register for a longword. The resulting memory bytes equal a byte-array reference model.
- R5: A load returns the addressed byte or word sign-extended from its top bit to 32 bits, and a longword unchanged. There is no zero-extending load.
- R6: A word request with address bit 0 set raises `addr_err` for one cycle. In that cycle `bus_valid` is low and `bus_be` is zero.
- R7: A longword request with address bits 1:0 not both zero raises `addr_err` with no bus access, and a load that raised the error never produces `ld_valid`. A byte request is never in error.
- R8: While `rst_n` is low, `endian_pin` low selects big-endian and high selects little-endian.
- R9: After reset is released, changes on `endian_pin` have no effect until the next reset.
- R10: Bus outputs appear on the clock edge after the request. `ld_valid` equals `rd_valid` while a legal load is outstanding. `ld_data` is valid in that same cycle.
- R11: During reset and right after it, `bus_valid`, `addr_err`, `ld_valid` and `bus_be` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| endian_pin | input | 1 | Byte-order strap, sampled during reset (0 big, 1 little) |
| req_valid | input | 1 | Access request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Register value to store |
| bus_valid | output | 1 | Bus access issued |
| bus_we | output | 1 | Bus write |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_be | output | 4 | Per-lane byte enables |
| bus_wdata | output | 32 | Lane-steered store data |
| addr_err | output | 1 | Misaligned access pulse |
| rd_valid | input | 1 | Bus read data valid |
| rd_data | input | 32 | Bus read data |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Sign-extended load result |

## Verification
A wrong latched byte order moves every byte and word onto the mirrored lane. The first sub-longword store after reset then writes the wrong memory bytes, and the next load returns swapped data. Stale captured size or offset bits show up only at the first load result that depends on them. A bad alignment decode shows one cycle after the offending request, as a missing or spurious error pulse together with unexpected enables. The sweep therefore stores through every size and offset in both byte orders. It reads each result back at every size and offset against a byte-array model, and it toggles the strap after reset.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int DW    = 32;
  localparam int NLANE = DW / 8;
  localparam int OFS_W = $clog2(NLANE);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;
endpackage

// File: rtl/lsa_rst_sync.sv
module lsa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
(
  input  size_e            size,
  input  logic [OFS_W-1:0] ofs,
  input  logic             le,
  input  logic [DW-1:0]    reg_data,
  output logic [NLANE-1:0] be,
  output logic [DW-1:0]    lane_data,
  output logic             misalign
);
  logic             is_byte, is_word, is_long;
  logic [OFS_W-1:0] blane;
  logic             upper;
  logic [NLANE-1:0] be_raw;

  always_comb begin
    is_byte  = (size == SZ_BYTE);
    is_word  = (size == SZ_WORD);
    is_long  = !is_byte && !is_word;
    blane    = le ? ofs : ~ofs;
    upper    = (ofs[OFS_W-1] == le);
    misalign = (is_word && ofs[0]) || (is_long && (ofs != '0));
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(k);
    localparam bit               HI_HALF = (k >= NLANE / 2);
    assign be_raw[k] = is_long
                     | (is_word & (HI_HALF == upper))
                     | (is_byte & (blane == LANE_ID));
  end

  always_comb begin
    be = misalign ? '0 : be_raw;
    if (is_byte)      lane_data = {NLANE{reg_data[7:0]}};
    else if (is_word) lane_data = {2{reg_data[DW/2-1:0]}};
    else              lane_data = reg_data;
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  size_e            size,
  input  logic [OFS_W-1:0] ofs,
  input  logic             le,
  input  logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    ld_data
);
  logic [7:0]       lane_b [NLANE];
  logic [OFS_W-1:0] blane;
  logic             upper;
  logic [7:0]       bsel;
  logic [DW/2-1:0]  hsel;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign lane_b[k] = rd_data[8*k +: 8];
  end

  always_comb begin
    blane = le ? ofs : ~ofs;
    upper = (ofs[OFS_W-1] == le);
    bsel  = lane_b[blane];
    hsel  = upper ? rd_data[DW-1:DW/2] : rd_data[DW/2-1:0];
    case (size)
      SZ_BYTE: ld_data = {{(DW-8){bsel[7]}}, bsel};
      SZ_WORD: ld_data = {{(DW/2){hsel[DW/2-1]}}, hsel};
      default: ld_data = rd_data;
    endcase
  end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              endian_pin,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_be,
  output logic [31:0]       bus_wdata,
  output logic              addr_err,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              ld_valid,
  output logic [31:0]       ld_data
);
  logic             srst_n;
  logic             endian_le_q;
  size_e            size_in, size_q;
  logic [NLANE-1:0] be_c;
  logic [DW-1:0]    lane_c;
  logic             mis_c;
  logic             issue;
  logic             bus_valid_d, bus_valid_q;
  logic             err_d, err_q;
  logic [NLANE-1:0] be_d, be_q;
  logic             pend_d, pend_q;
  logic             we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]    wdata_q;

  lsa_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Strap capture: enabled only while reset is held.
  always_ff @(posedge clk) begin
    if (!srst_n) endian_le_q <= endian_pin;
  end

  assign size_in = size_e'(req_size);

  lsa_store_steer i_steer (
    .size      (size_in),
    .ofs       (req_addr[OFS_W-1:0]),
    .le        (endian_le_q),
    .reg_data  (req_wdata),
    .be        (be_c),
    .lane_data (lane_c),
    .misalign  (mis_c)
  );

  always_comb begin
    issue       = req_valid && !mis_c;
    bus_valid_d = issue;
    err_d       = req_valid && mis_c;
    be_d        = issue ? be_c : '0;
    if (issue && !req_store) pend_d = 1'b1;
    else if (rd_valid)       pend_d = 1'b0;
    else                     pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bus_valid_q <= 1'b0;
      err_q       <= 1'b0;
      be_q        <= '0;
      pend_q      <= 1'b0;
    end else begin
      bus_valid_q <= bus_valid_d;
      err_q       <= err_d;
      be_q        <= be_d;
      pend_q      <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      we_q    <= req_store;
      addr_q  <= req_addr;
      wdata_q <= lane_c;
      size_q  <= size_in;
    end
  end

  lsa_load_extract i_extract (
    .size    (size_q),
    .ofs     (addr_q[OFS_W-1:0]),
    .le      (endian_le_q),
    .rd_data (rd_data),
    .ld_data (ld_data)
  );

  assign bus_valid = bus_valid_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_be    = be_q;
  assign bus_wdata = wdata_q;
  assign addr_err  = err_q;
  assign ld_valid  = rd_valid && pend_q;
endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       req_valid,
  input logic [1:0] req_size,
  input logic [1:0] req_ofs,
  input logic       bus_valid,
  input logic [3:0] bus_be,
  input logic       addr_err,
  input logic       rd_valid,
  input logic       ld_valid,
  input logic [31:0] ld_data,
  input logic [1:0] size_q,
  input logic       endian_le_q
);
  p_be_count_r1: assert property (@(posedge clk) disable iff (!srst_n)
    bus_valid |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 || $countones(bus_be) == 4));

  p_be_idle_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_valid |-> bus_be == 4'b0000);

  p_byte_legal_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_size == 2'd0) |=> (bus_valid && !addr_err && $countones(bus_be) == 1));

  p_word_misalign_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_size == 2'd1 && req_ofs[0]) |=> (addr_err && !bus_valid));

  p_long_misalign_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_size == 2'd2 && req_ofs != 2'd0) |=> (addr_err && !bus_valid));

  p_err_no_lanes_r6: assert property (@(posedge clk) disable iff (!srst_n)
    addr_err |-> (bus_be == 4'b0000 && !bus_valid));

  p_endian_locked_r9: assert property (@(posedge clk) disable iff (!srst_n)
    srst_n |=> $stable(endian_le_q));

  p_ld_gated_r10: assert property (@(posedge clk) disable iff (!srst_n)
    ld_valid |-> rd_valid);

  p_ld_sign_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (ld_valid && size_q == 2'd0) |-> ld_data[31:8] == {24{ld_data[7]}});
endmodule

bind lsa_unit lsa_unit_chk i_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .req_valid   (req_valid),
  .req_size    (req_size),
  .req_ofs     (req_addr[1:0]),
  .bus_valid   (bus_valid),
  .bus_be      (bus_be),
  .addr_err    (addr_err),
  .rd_valid    (rd_valid),
  .ld_valid    (ld_valid),
  .ld_data     (ld_data),
  .size_q      (size_q),
  .endian_le_q (endian_le_q)
);

// File: tb/test_lsa_unit.sv
module test_lsa_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int MEM_N      = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              endian_pin;
  logic              req_valid, req_store;
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              bus_valid, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [3:0]        bus_be;
  logic [31:0]       bus_wdata;
  logic              addr_err;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic              ld_valid;
  logic [31:0]       ld_data;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  bit  cur_le;
  logic [7:0] ref_mem [MEM_N];
  logic [7:0] bus_mem [MEM_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsa_unit #(.ADDR_W(ADDR_W)) i_lsa_unit (
    .clk(clk), .rst_n(rst_n), .endian_pin(endian_pin),
    .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .addr_err(addr_err),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic bit misaligned(input int sz, input int a);
    return (sz == 1 && (a % 2) != 0) || (sz == 2 && (a % 4) != 0);
  endfunction

  function automatic int lane_of(input int a, input bit le);
    return le ? (a % 4) : 3 - (a % 4);
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input int a, input bit le);
    logic [3:0] be = '0;
    for (int i = 0; i < nbytes(sz); i++) be[lane_of(a + i, le)] = 1'b1;
    return be;
  endfunction

  task automatic do_reset(input bit pin);
    rst_n      = 1'b0;
    endian_pin = pin;
    req_valid  = 1'b0;
    req_store  = 1'b0;
    req_size   = '0;
    req_addr   = '0;
    req_wdata  = '0;
    rd_valid   = 1'b0;
    rd_data    = '0;
    for (int i = 0; i < MEM_N; i++) begin
      ref_mem[i] = '0;
      bus_mem[i] = '0;
    end
    repeat (4) @(negedge clk);
    // R11: idle outputs while reset is held
    chk(!bus_valid && !addr_err && !ld_valid && bus_be == 4'b0, "R11 in reset",
        {bus_valid, addr_err, ld_valid, bus_be}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_valid && !addr_err && !ld_valid && bus_be == 4'b0, "R11 after reset",
        {bus_valid, addr_err, ld_valid, bus_be}, 32'h0);
    cur_le     = pin;
    endian_pin = ~pin; // R9: strap moves after reset, must be ignored
  endtask

  task automatic access(input bit st, input int sz, input int a, input logic [31:0] d);
    bit          bad = misaligned(sz, a);
    logic [31:0] exp_v;
    logic [31:0] word;
    int          base;
    int          n = nbytes(sz);
    @(negedge clk);
    req_valid = 1'b1;
    req_store = st;
    req_size  = 2'(sz);
    req_addr  = ADDR_W'(a);
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(addr_err == bad, sz == 2 ? "R7 error flag" : "R6 error flag", 32'(addr_err), 32'(bad));
    chk(bus_valid == !bad, "R10 bus issue", 32'(bus_valid), 32'(!bad));
    if (bad) begin
      chk(bus_be == 4'b0, "R6 R7 no lanes on error", 32'(bus_be), 32'h0);
      if (!st) begin
        rd_valid = 1'b1;
        #1;
        chk(!ld_valid, "R7 no load result", 32'(ld_valid), 32'h0);
        @(negedge clk);
        rd_valid = 1'b0;
      end
      return;
    end
    chk(bus_be == exp_be(sz, a, cur_le), cur_le ? "R3 R9 enables" : "R2 R9 enables",
        32'(bus_be), 32'(exp_be(sz, a, cur_le)));
    chk($countones(bus_be) == n, "R1 enable count", 32'($countones(bus_be)), 32'(n));
    base = a - (a % 4);
    if (st) begin
      for (int i = 0; i < n; i++)
        ref_mem[a + i] = cur_le ? d[8*i +: 8] : d[8*(n-1-i) +: 8];
      for (int k = 0; k < 4; k++)
        if (bus_be[k]) bus_mem[base + (cur_le ? k : 3 - k)] = bus_wdata[8*k +: 8];
      for (int i = 0; i < MEM_N; i++)
        chk(bus_mem[i] == ref_mem[i], "R4 memory byte", 32'(bus_mem[i]), 32'(ref_mem[i]));
    end else begin
      for (int k = 0; k < 4; k++) word[8*k +: 8] = bus_mem[base + (cur_le ? k : 3 - k)];
      exp_v = '0;
      for (int i = 0; i < n; i++) begin
        if (cur_le) exp_v[8*i +: 8] = ref_mem[a + i];
        else        exp_v[8*(n-1-i) +: 8] = ref_mem[a + i];
      end
      if (n == 1) exp_v = {{24{exp_v[7]}}, exp_v[7:0]};
      if (n == 2) exp_v = {{16{exp_v[15]}}, exp_v[15:0]};
      chk(!ld_valid, "R10 no result before data", 32'(ld_valid), 32'h0);
      rd_data  = word;
      rd_valid = 1'b1;
      #1;
      chk(ld_valid, "R10 load valid", 32'(ld_valid), 32'h1);
      chk(ld_data == exp_v, "R5 load data", ld_data, exp_v);
      @(negedge clk);
      rd_valid = 1'b0;
    end
  endtask

  initial begin
    int idx = 0;
    logic [31:0] pat;
    for (int e = 0; e < 2; e++) begin
      do_reset(e[0]);
      // R8: first byte store at offset 0 selects lane 3 (big) or lane 0 (little)
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b1; req_size = 2'd0; req_addr = '0; req_wdata = 32'h5A;
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_be == (e[0] ? 4'b0001 : 4'b1000), "R8 strap lane", 32'(bus_be),
          32'(e[0] ? 4'b0001 : 4'b1000));
      ref_mem[0] = 8'h5A;
      bus_mem[0] = 8'h5A;
      for (int b = 0; b < MEM_N; b += 4)
        for (int sz = 0; sz < 3; sz++)
          for (int o = 0; o < 4; o++)
            for (int p = 0; p < 2; p++) begin
              idx++;
              pat = 32'h96F1_83A5 ^ (32'(idx) * 32'h0137_2B4D);
              if (p == 1) pat = ~pat;
              access(1'b1, sz, b + o, pat);
              for (int ls = 0; ls < 3; ls++)
                for (int lo = 0; lo < 4; lo++)
                  access(1'b0, ls, b + lo, 32'h0);
            end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule